// File: doc/BRIEF.md
# Dual-Port Two-Bank Interleaved Memory

This block is the single storage that a pipelined processor uses for both its code and its data. Two requesters reach it at once. The instruction-fetch port can only read. The data port serves word loads and stores. The storage is split into two banks that alternate on consecutive 32-bit words. Each bank serves at most one access per cycle.

In every cycle the block works out which bank each active port addresses. When the two ports land in different banks, both are served in that cycle. When they land in the same bank, the data port wins, because it belongs to the older instruction. The fetch request is refused and `stallFetch` is raised, so that the pipeline holds its program counter and fetch register and retries in the next cycle.

Reads return data one cycle after the request is granted, marked by a per-port valid flag. Stores write only the bytes whose enables are set. A word stored through the data port can later be fetched as an instruction, because both ports see the same storage.

Top module: `bankedSharedMem`

## Requirements
- R1: Byte address bit 2 selects the bank (0 or 1), and address bits [10:3] select the word within the bank. Two addresses that differ only in bit 2 hold independent words.
- R2: When both ports are active and address different banks, `stallFetch` stays low and both reads are served in that cycle.
- R3: When both ports are active and address the same bank, `stallFetch` is high in that cycle. The data access is performed, and the fetch is not served, so `fetchRvalid` is low in the next cycle.
- R4: An idle port never causes a conflict. `stallFetch` is low whenever `fetchReq` or `dataReq` is low.
- R5: A granted read raises its port's `*Rvalid` exactly one cycle later, with the addressed word on `*Rdata`. A data-port write (`dataWe`=1) or an idle cycle gives `dataRvalid`=0 in the next cycle.
- R6: A store changes only the bytes whose enable bit is 1. `dataBe[i]` covers data bits [8i+7:8i], and the other bytes of the word keep their old value.
- R7: Instruction and data share one storage, so a fetch read returns the word that the data port last stored at that address.
- R8: While `rstN` is low and in the first cycle after reset, `fetchRvalid`, `dataRvalid` and `stallFetch` are 0 when no request is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Fetch read request |
| fetchAddr | input | ADDR_W | Fetch byte address |
| stallFetch | output | 1 | Fetch refused this cycle because of a bank conflict |
| fetchRvalid | output | 1 | Fetch read data valid (one cycle after grant) |
| fetchRdata | output | DATA_W | Fetch read data |
| dataReq | input | 1 | Data port request |
| dataWe | input | 1 | 1 = store, 0 = load |
| dataBe | input | DATA_W/8 | Byte write enables for stores |
| dataAddr | input | ADDR_W | Data byte address |
| dataWdata | input | DATA_W | Store data |
| dataRvalid | output | 1 | Load data valid (one cycle after request) |
| dataRdata | output | DATA_W | Load data |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 16-bit byte address and 256 words per bank. With these values the bank bit is address bit 2, and every address below 0x800 maps to a distinct word. A shadow memory in the bench can then predict every read. The bench drives a fetch stream and a data stream that both step by 4 with one address stride. With a data base of matching bank parity, every cycle is a conflict. With the opposite parity, no cycle is. The bench also runs partial byte-enable stores and fetches of words that the data port has just written.

// File: rtl/bsmPkg.sv
package bsmPkg;
  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic fetchEn;       // fetch granted this cycle
    logic fetchBank;     // bank addressed by the fetch port
    logic dataEn;        // data port active this cycle
    logic dataWr;        // data port access is a store
    logic dataBank;      // bank addressed by the data port
    logic fetchOutBank;  // bank that produced the last granted fetch read
    logic dataOutBank;   // bank that produced the last data read
  } memStrobe_t;
endpackage

// File: rtl/bsmCtrl.sv
module bsmCtrl
  import bsmPkg::*;
#(
  parameter int BANK_BIT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fetchReq,
  input  logic       fetchBankIn,
  input  logic       dataReq,
  input  logic       dataWe,
  input  logic       dataBankIn,
  output logic       stallFetch,
  output logic       fetchRvalid,
  output logic       dataRvalid,
  output memStrobe_t strobe
);

  logic conflict;
  logic fetchOutBankQ, dataOutBankQ;
  logic fetchRvalidQ, dataRvalidQ;

  always_comb begin
    conflict            = fetchReq && dataReq && (fetchBankIn == dataBankIn);
    strobe.fetchEn      = fetchReq && !conflict;
    strobe.fetchBank    = fetchBankIn;
    strobe.dataEn       = dataReq;
    strobe.dataWr       = dataReq && dataWe;
    strobe.dataBank     = dataBankIn;
    strobe.fetchOutBank = fetchOutBankQ;
    strobe.dataOutBank  = dataOutBankQ;
  end

  assign stallFetch = conflict;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchRvalidQ  <= 1'b0;
      dataRvalidQ   <= 1'b0;
      fetchOutBankQ <= 1'b0;
      dataOutBankQ  <= 1'b0;
    end else begin
      fetchRvalidQ <= strobe.fetchEn;
      dataRvalidQ  <= dataReq && !dataWe;
      if (strobe.fetchEn) fetchOutBankQ <= fetchBankIn;
      if (dataReq && !dataWe) dataOutBankQ <= dataBankIn;
    end
  end

  assign fetchRvalid = fetchRvalidQ;
  assign dataRvalid  = dataRvalidQ;

  AST_FETCH_GRANT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !stallFetch) |=> fetchRvalid); // R5
  AST_STALL_NO_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    stallFetch |=> !fetchRvalid); // R3
  AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (dataReq && !dataWe) |=> dataRvalid); // R5
  AST_NO_LOAD_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (!dataReq || dataWe) |=> !dataRvalid); // R5
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchReq || !dataReq) |-> !stallFetch); // R4
  AST_DIFF_BANK_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (fetchBankIn != dataBankIn) |-> !stallFetch); // R2

endmodule

// File: rtl/bsmDatapath.sv
module bsmDatapath
  import bsmPkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int WORDS_PER_BANK = 256,
  localparam int IDX_W         = $clog2(WORDS_PER_BANK),
  localparam int BYTES         = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [IDX_W-1:0]  fetchIdx,
  input  logic [IDX_W-1:0]  dataIdx,
  input  logic [BYTES-1:0]  dataBe,
  input  logic [DATA_W-1:0] dataWdata,
  output logic [DATA_W-1:0] fetchRdata,
  output logic [DATA_W-1:0] dataRdata
);

  logic [DATA_W-1:0] bankRd [2];

  for (genvar b = 0; b < 2; b++) begin : gBank
    logic [DATA_W-1:0] mem [WORDS_PER_BANK];
    logic [DATA_W-1:0] rdQ;
    logic              dataHere, fetchHere;
    logic [IDX_W-1:0]  idx;

    assign dataHere  = strobe.dataEn  && (strobe.dataBank  == 1'(b));
    assign fetchHere = strobe.fetchEn && (strobe.fetchBank == 1'(b));
    assign idx       = dataHere ? dataIdx : fetchIdx;

    always_ff @(posedge clk) begin
      if (dataHere && strobe.dataWr) begin
        for (int i = 0; i < BYTES; i++) begin
          if (dataBe[i]) mem[idx][i*8 +: 8] <= dataWdata[i*8 +: 8];
        end
      end else if (dataHere || fetchHere) begin
        rdQ <= mem[idx];
      end
    end

    assign bankRd[b] = rdQ;

    AST_BANK_ONE_PORT: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({dataHere, fetchHere})); // R3
  end

  assign fetchRdata = bankRd[strobe.fetchOutBank];
  assign dataRdata  = bankRd[strobe.dataOutBank];

endmodule

// File: rtl/bankedSharedMem.sv
module bankedSharedMem
  import bsmPkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 32,
  parameter int WORDS_PER_BANK = 256,
  localparam int BYTES         = DATA_W / 8,
  localparam int OFF_W         = $clog2(BYTES),
  localparam int IDX_W         = $clog2(WORDS_PER_BANK),
  localparam int IDX_LSB       = OFF_W + 1,
  localparam int TOP_LSB       = IDX_LSB + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              stallFetch,
  output logic              fetchRvalid,
  output logic [DATA_W-1:0] fetchRdata,
  input  logic              dataReq,
  input  logic              dataWe,
  input  logic [BYTES-1:0]  dataBe,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [DATA_W-1:0] dataWdata,
  output logic              dataRvalid,
  output logic [DATA_W-1:0] dataRdata
);

  memStrobe_t strobe;

  // Address bits outside bank select and word index do not take part
  logic unusedAddrBits;
  assign unusedAddrBits = ^{fetchAddr[ADDR_W-1:TOP_LSB], fetchAddr[OFF_W-1:0],
                            dataAddr[ADDR_W-1:TOP_LSB],  dataAddr[OFF_W-1:0]};

  bsmCtrl #(.BANK_BIT(OFF_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .fetchReq    (fetchReq),
    .fetchBankIn (fetchAddr[OFF_W]),
    .dataReq     (dataReq),
    .dataWe      (dataWe),
    .dataBankIn  (dataAddr[OFF_W]),
    .stallFetch  (stallFetch),
    .fetchRvalid (fetchRvalid),
    .dataRvalid  (dataRvalid),
    .strobe      (strobe)
  );

  bsmDatapath #(
    .DATA_W         (DATA_W),
    .WORDS_PER_BANK (WORDS_PER_BANK)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fetchIdx   (fetchAddr[IDX_LSB +: IDX_W]),
    .dataIdx    (dataAddr[IDX_LSB +: IDX_W]),
    .dataBe     (dataBe),
    .dataWdata  (dataWdata),
    .fetchRdata (fetchRdata),
    .dataRdata  (dataRdata)
  );

endmodule

// File: tb/bankedSharedMem_tb.sv
module bankedSharedMem_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        fetchReq;
  logic [15:0] fetchAddr;
  logic        stallFetch, fetchRvalid, dataRvalid;
  logic [31:0] fetchRdata, dataRdata;
  logic        dataReq, dataWe;
  logic [3:0]  dataBe;
  logic [15:0] dataAddr;
  logic [31:0] dataWdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] model [512];
  logic        stallSeen, fRv, dRv;
  logic [31:0] fRd, dRd;

  always #4 clk = ~clk;

  bankedSharedMem u_dut (
    .clk(clk), .rstN(rstN),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .stallFetch(stallFetch),
    .fetchRvalid(fetchRvalid), .fetchRdata(fetchRdata),
    .dataReq(dataReq), .dataWe(dataWe), .dataBe(dataBe), .dataAddr(dataAddr),
    .dataWdata(dataWdata), .dataRvalid(dataRvalid), .dataRdata(dataRdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mrd(input logic [15:0] a);
    return model[a[10:2]];
  endfunction

  // One access cycle: drive at negedge, sample stall, sample outputs one edge later
  task automatic doCycle(input logic fr, input logic [15:0] fa, input logic dr,
                         input logic dw, input logic [3:0] be, input logic [15:0] da,
                         input logic [31:0] wd);
    fetchReq = fr; fetchAddr = fa;
    dataReq = dr; dataWe = dw; dataBe = be; dataAddr = da; dataWdata = wd;
    #1 stallSeen = stallFetch;
    @(negedge clk);
    fRv = fetchRvalid; fRd = fetchRdata; dRv = dataRvalid; dRd = dataRdata;
    if (dr && dw) begin
      for (int i = 0; i < 4; i++)
        if (be[i]) model[da[10:2]][i*8 +: 8] = wd[i*8 +: 8];
    end
    fetchReq = 1'b0; dataReq = 1'b0; dataWe = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0; fetchReq = 0; dataReq = 0; dataWe = 0; dataBe = 0;
    fetchAddr = 0; dataAddr = 0; dataWdata = 0;
    repeat (3) @(negedge clk);
    chk("R8 stall in reset", {31'b0, stallFetch}, 32'd0);
    chk("R8 fetchRvalid in reset", {31'b0, fetchRvalid}, 32'd0);
    chk("R8 dataRvalid in reset", {31'b0, dataRvalid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 valids after reset", {30'b0, fetchRvalid, dataRvalid}, 32'd0);
  endtask

  task automatic testFill();
    for (int k = 0; k < 8; k++) begin
      doCycle(0, 0, 1, 1, 4'hF, 16'h0100 + 16'(k*4), 32'hC0DE0000 + 32'(k));
      chk("R5 no dataRvalid after store", {31'b0, dRv}, 32'd0);
      chk("R4 data alone no stall", {31'b0, stallSeen}, 32'd0);
    end
    doCycle(0, 0, 1, 0, 4'h0, 16'h0100, 0);
    chk("R5 dataRvalid after load", {31'b0, dRv}, 32'd1);
    chk("R1 word 0x100", dRd, mrd(16'h0100));
    doCycle(0, 0, 1, 0, 4'h0, 16'h0104, 0);
    chk("R1 word 0x104 independent", dRd, mrd(16'h0104));
  endtask

  task automatic testDiffBank();
    doCycle(1, 16'h0100, 1, 0, 0, 16'h0104, 0);
    chk("R2 no stall diff bank", {31'b0, stallSeen}, 32'd0);
    chk("R2 both valid", {30'b0, fRv, dRv}, 32'd3);
    chk("R2 fetch data", fRd, mrd(16'h0100));
    chk("R2 data data", dRd, mrd(16'h0104));
  endtask

  task automatic testSameBank();
    doCycle(1, 16'h0108, 1, 0, 0, 16'h0100, 0);
    chk("R3 stall same bank", {31'b0, stallSeen}, 32'd1);
    chk("R3 fetch refused", {31'b0, fRv}, 32'd0);
    chk("R3 data served", {31'b0, dRv}, 32'd1);
    chk("R3 data word", dRd, mrd(16'h0100));
    doCycle(1, 16'h0108, 0, 0, 0, 0, 0);
    chk("R4 fetch alone no stall", {31'b0, stallSeen}, 32'd0);
    chk("R3 retried fetch word", fRd, mrd(16'h0108));
    doCycle(1, 16'h010C, 1, 1, 4'hF, 16'h0104, 32'h5A5A1234);
    chk("R3 stall on same-bank store", {31'b0, stallSeen}, 32'd1);
    chk("R3 fetch refused on store", {31'b0, fRv}, 32'd0);
    doCycle(1, 16'h0104, 0, 0, 0, 0, 0);
    chk("R7 fetch sees stored word", fRd, 32'h5A5A1234);
  endtask

  task automatic testByteEn();
    doCycle(0, 0, 1, 1, 4'hF, 16'h0200, 32'hAABBCCDD);
    doCycle(0, 0, 1, 1, 4'b0101, 16'h0200, 32'h11223344);
    doCycle(1, 16'h0200, 0, 0, 0, 0, 0);
    chk("R6 partial store", fRd, 32'hAA22CC44);
    chk("R7 fetch after data store", {31'b0, fRv}, 32'd1);
  endtask

  task automatic testWalk(input logic [15:0] dBase);
    for (int k = 0; k < 6; k++) begin
      logic [15:0] fa, da;
      fa = 16'h0100 + 16'(k*4);
      da = dBase + 16'(k*4);
      doCycle(1, fa, 1, 1, 4'hF, da, 32'hBEEF0000 + 32'(k));
      chk("R1 walk stall by bank bit", {31'b0, stallSeen}, {31'b0, fa[2] == da[2]});
      chk("R2 walk fetch valid", {31'b0, fRv}, {31'b0, fa[2] != da[2]});
      if (fa[2] != da[2]) chk("R2 walk fetch word", fRd, mrd(fa));
    end
    for (int k = 0; k < 6; k++) begin
      doCycle(1, dBase + 16'(k*4), 0, 0, 0, 0, 0);
      chk("R7 walk fetch of stored word", fRd, 32'hBEEF0000 + 32'(k));
    end
  endtask

  initial begin
    testReset();
    testFill();
    testDiffBank();
    testSameBank();
    testByteEn();
    testWalk(16'h0300);
    testWalk(16'h0404);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule